// File: doc/BRIEF.md
# Edge-Triggered Non-Maskable Interrupt Controller

This block turns an asynchronous non-maskable interrupt pin into a request to a processor core. The pin passes through a two-flop synchroniser. A rising edge then raises a request that carries a fixed vector generated inside the block. Taking the interrupt needs nothing from the core except a one-cycle accept strobe. No acknowledge cycle goes out to fetch a vector.

Once the core accepts, the block counts the handler as in service until an end-of-interrupt strobe arrives. One edge that lands during service is remembered and raised as a new request when the handler finishes. Any further edges in that window are lost. A configuration input hands the pin to a generic local interrupt line instead. Edges then come out as single-cycle pulses on a separate output, and the non-maskable logic never sees them.

Top module: `nmi_edge_ctrl`

## Requirements
- R1: After reset `nmi_req`, `in_service` and `lint_pulse` are 0 and `nmi_vector` is 0.
- R2: With `route_lint` = 0, a rising edge on `pin_in` sets `nmi_req` on the third rising clock edge after the pin change. A pin that stays high raises no further request after the first has been serviced.
- R3: `nmi_vector` reads 2 whenever `nmi_req` is 1 and 0 otherwise.
- R4: `core_accept` while `nmi_req` = 1 clears `nmi_req` and sets `in_service` on the next clock edge. `nmi_req` and `in_service` are never 1 together.
- R5: An edge that arrives while `in_service` = 1 does not raise `nmi_req` until `eoi` is strobed. The request then appears on the clock edge that samples `eoi`.
- R6: At most one edge is kept pending during service. Several edges during one service produce exactly one request after `eoi`.
- R7: An edge that arrives while `nmi_req` is already 1 and not yet accepted is discarded.
- R8: With `route_lint` = 1, each synchronised rising edge gives a `lint_pulse` exactly one cycle wide, and `nmi_req` stays 0.
- R9: `eoi` while `in_service` = 0 has no effect.
- R10: Pulses held high for two clocks and low for two clocks are each recognised as a separate edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw asynchronous interrupt pin |
| route_lint | input | 1 | 1 = pin drives the local interrupt line, 0 = non-maskable interrupt |
| core_accept | input | 1 | Core takes the pending request (one-cycle strobe) |
| eoi | input | 1 | End-of-interrupt strobe from the handler |
| nmi_req | output | 1 | Non-maskable interrupt request to the core |
| nmi_vector | output | VEC_W | Internal vector, 2 while a request is raised |
| in_service | output | 1 | Handler running |
| lint_pulse | output | 1 | One-cycle pulse per edge in local interrupt mode |

## Verification
The hardest state to reach from the ports is an edge that is already held pending while the handler runs, followed by more edges before end-of-interrupt. The stimulus accepts a request and then sends several minimum-width pulses with accept and eoi both idle. It then strobes eoi and checks for exactly one new request. After that request is accepted and retired, the bench waits to confirm that the discarded edges never come back.

// File: rtl/nmi_edge_ctrl.sv
module nmi_edge_ctrl #(
  parameter int VEC_W  = 8,
  parameter int VECTOR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             route_lint,
  input  logic             core_accept,
  input  logic             eoi,
  output logic             nmi_req,
  output logic [VEC_W-1:0] nmi_vector,
  output logic             in_service,
  output logic             lint_pulse
);

  logic meta_q, sync_q, prev_q;
  logic req_q, svc_q, held_q;
  logic rise, nmi_edge, take, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise       = sync_q & ~prev_q;
  assign nmi_edge   = rise & ~route_lint;
  assign lint_pulse = rise & route_lint;
  assign take       = req_q & core_accept;
  assign done       = svc_q & eoi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      svc_q  <= 1'b0;
      held_q <= 1'b0;
    end else if (take) begin
      req_q  <= 1'b0;
      svc_q  <= 1'b1;
      held_q <= nmi_edge;
    end else if (done) begin
      req_q  <= held_q | nmi_edge;
      svc_q  <= 1'b0;
      held_q <= 1'b0;
    end else if (svc_q) begin
      held_q <= held_q | nmi_edge;
    end else if (nmi_edge) begin
      req_q  <= 1'b1;
    end
  end

  assign nmi_req    = req_q;
  assign in_service = svc_q;
  assign nmi_vector = req_q ? VEC_W'(VECTOR) : '0;

endmodule

// File: rtl/nmi_edge_ctrl_chk.sv
module nmi_edge_ctrl_chk #(
  parameter int VEC_W  = 8,
  parameter int VECTOR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             route_lint,
  input logic             core_accept,
  input logic             eoi,
  input logic             nmi_req,
  input logic [VEC_W-1:0] nmi_vector,
  input logic             in_service,
  input logic             lint_pulse
);

  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req && core_accept |=> !nmi_req && in_service); // R4

  AST_REQ_SVC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && in_service)); // R4

  AST_VEC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> nmi_vector == VEC_W'(VECTOR)); // R3

  AST_HOLD_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    in_service && !eoi |=> !nmi_req); // R5

  AST_LINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lint_pulse |=> !lint_pulse); // R8

  AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !in_service && !nmi_req && !core_accept |=> !in_service); // R9

endmodule

bind nmi_edge_ctrl nmi_edge_ctrl_chk #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .route_lint(route_lint), .core_accept(core_accept),
  .eoi(eoi), .nmi_req(nmi_req), .nmi_vector(nmi_vector),
  .in_service(in_service), .lint_pulse(lint_pulse)
);

// File: tb/nmi_edge_ctrl_bench.sv
module nmi_edge_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0, route_lint = 1'b0, core_accept = 1'b0, eoi = 1'b0;
  logic nmi_req, in_service, lint_pulse;
  logic [VEC_W-1:0] nmi_vector;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_edge_ctrl #(.VEC_W(VEC_W), .VECTOR(2)) u_nmi_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .route_lint(route_lint),
    .core_accept(core_accept), .eoi(eoi), .nmi_req(nmi_req),
    .nmi_vector(nmi_vector), .in_service(in_service), .lint_pulse(lint_pulse)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_pin();
    pin_in = 1'b1; step(2);
    pin_in = 1'b0; step(2);
  endtask

  task automatic accept();
    core_accept = 1'b1; step(1); core_accept = 1'b0;
  endtask

  task automatic end_int();
    eoi = 1'b1; step(1); eoi = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req", nmi_req, 0);
    chk("R1 svc", in_service, 0);
    chk("R1 lint", lint_pulse, 0);
    chk("R1 vec", nmi_vector, 0);
  endtask

  task automatic t_latency();
    pin_in = 1'b1; step(2);
    chk("R2 early", nmi_req, 0);
    step(1);
    chk("R2 req", nmi_req, 1);
    chk("R3 vec", nmi_vector, 2);
    step(5);
    chk("R2 held", nmi_req, 1);
    accept();
    chk("R4 req clr", nmi_req, 0);
    chk("R4 svc", in_service, 1);
    chk("R3 vec zero", nmi_vector, 0);
    end_int();
    chk("R4 svc clr", in_service, 0);
    step(5);
    chk("R2 level no retrig", nmi_req, 0);
    pin_in = 1'b0; step(3);
  endtask

  task automatic t_pending();
    pulse_pin();
    chk("R5 first", nmi_req, 1);
    accept();
    pulse_pin(); step(3);
    chk("R5 held off", nmi_req, 0);
    end_int();
    chk("R5 after eoi", nmi_req, 1);
    chk("R5 svc", in_service, 0);
    accept(); end_int(); step(5);
    chk("R5 clean", nmi_req, 0);
  endtask

  task automatic t_single();
    pulse_pin(); accept();
    pulse_pin(); pulse_pin(); pulse_pin();
    chk("R6 held", nmi_req, 0);
    end_int();
    chk("R6 one req", nmi_req, 1);
    accept(); end_int(); step(6);
    chk("R6 no second", nmi_req, 0);
    chk("R6 idle", in_service, 0);
  endtask

  task automatic t_drop_outstanding();
    pulse_pin();
    pulse_pin();
    chk("R7 req", nmi_req, 1);
    accept(); end_int(); step(6);
    chk("R7 dropped", nmi_req, 0);
    chk("R7 idle", in_service, 0);
  endtask

  task automatic t_lint();
    int cnt = 0;
    route_lint = 1'b1;
    pin_in = 1'b1; step(2);
    chk("R8 pulse", lint_pulse, 1);
    step(1);
    chk("R8 width", lint_pulse, 0);
    pin_in = 1'b0; step(6);
    for (int i = 0; i < 14; i++) begin
      if (i == 0 || i == 4) pin_in = 1'b1;
      if (i == 2 || i == 6) pin_in = 1'b0;
      step(1);
      if (lint_pulse) cnt++;
    end
    chk("R10 two edges", cnt, 2);
    chk("R8 no nmi", nmi_req, 0);
    route_lint = 1'b0; step(4);
    chk("R8 still no nmi", nmi_req, 0);
  endtask

  task automatic t_eoi_idle();
    end_int(); step(3);
    chk("R9 req", nmi_req, 0);
    chk("R9 svc", in_service, 0);
    pulse_pin();
    chk("R9 normal after", nmi_req, 1);
    accept(); end_int(); step(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_latency();
    t_pending();
    t_single();
    t_drop_outstanding();
    t_lint();
    t_eoi_idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule